// File: doc/BRIEF.md
# Circular Message Frame Queue Manager

This block keeps four circular queues of 32-bit frame addresses that carry message frames between a remote bus master and a local processor. Two queues serve the inbound direction (free frames handed to the remote side, and messages the remote side posts) and two serve the outbound direction (messages the local side posts, and frames the remote side returns). Every queue has its own head and tail pointer. All four share one size setting and one base address register.

The remote master sees two queue ports. A read of the inbound port allocates a free frame and a write to it posts a message. A read of the outbound port fetches a posted message and a write to it returns a frame. The local processor works the pointer registers directly, and reaches the queue storage through a word window. Two level interrupts tell the local side about posted inbound messages or an overflow, and tell the remote side about posted outbound messages. All accesses go through one register bus. Read data is registered: it appears after the clock edge that samples `bus_rd` and holds until the next read.

Top module: `msg_queue_mgr`

## Requirements
- R1: After reset all pointers are 0, the control register reads 0x00000200, the read data bus is 0 and both interrupts are low.
- R2: The control register at 0x164 holds the enable in bit 0, the post interrupt enable in bit 1, the overflow interrupt enable in bit 2, the size code in bits 13:8 and the overflow flag in bit 16. Valid size codes are 0x02, 0x04, 0x08, 0x10 and 0x20, and give code times UNIT_ENTRIES entries per queue (8 to 128 by default). A write carrying any other size code keeps the previous size and still updates the other bits.
- R3: A read of the inbound port (0x40) returns the entry at the inbound free queue tail (pointer 0x128) and advances that tail by one.
- R4: A write to the inbound port stores the data at the inbound post queue head (pointer 0x130) and advances that head by one.
- R5: A read of the outbound port (0x44) returns the entry at the outbound post queue tail (pointer 0x158) and advances that tail by one.
- R6: A write to the outbound port stores the data at the outbound free queue head (pointer 0x140) and advances that head by one.
- R7: A port read whose source queue is empty, or any port read while the enable is 0, returns 0xFFFFFFFF and moves no pointer. A port write while the enable is 0 is ignored.
- R8: A queue is empty when head equals tail and full when head plus one equals tail, so it holds one entry less than its size. A port write to a full queue is discarded, leaves the head unchanged and sets the overflow flag; writing 1 to control bit 16 clears the flag.
- R9: Pointers advance modulo the queue size. Pointer registers hold entry indices: inbound free head/tail 0x120/0x128, inbound post 0x130/0x138, outbound free 0x140/0x148, outbound post 0x150/0x158; a written value is masked to the queue size.
- R10: `irq_local` is high when enabled and either the post interrupt enable is set with the inbound post queue not empty, or the overflow interrupt enable is set with the overflow flag set. `irq_remote` is high when enabled, the post interrupt enable is set and the outbound post queue is not empty.
- R11: The base register at 0x170 keeps bits 31:20 of a write; bits 19:0 read as 0.
- R12: Queue storage is a word window at 0x1000 + 4*(q*128 + i), entry i of queue q, with q = 0 inbound free, 1 inbound post, 2 outbound free, 3 outbound post.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe; has priority over a write in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_local | output | 1 | Interrupt to the local processor |
| irq_remote | output | 1 | Interrupt to the remote master |

## Verification
A pointer that advances wrongly or misses its wrap shows up on the very next port read as a wrong frame address or a premature 0xFFFFFFFF, and in the pointer registers one read later. A wrong empty or full decision moves an interrupt line in the same cycle as the pointer update, or lets an overflowing post silently overwrite the oldest entry, which the overflow flag and the head readback expose at once. Posting exactly one queue size of entries after a wrap therefore covers both the modulo arithmetic and the full test.

// File: rtl/msg_queue_mgr.sv
module msg_queue_mgr #(
  parameter int UNIT_ENTRIES = 4,
  parameter int ADDR_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_local,
  output logic              irq_remote
);
  localparam int MAXE = UNIT_ENTRIES * 32;
  localparam int IDXW = $clog2(MAXE);
  localparam int MEMW = IDXW + 2;
  localparam logic [ADDR_W-1:0] A_INPORT  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_OUTPORT = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'('h164);
  localparam logic [ADDR_W-1:0] A_BASE    = ADDR_W'('h170);

  logic [IDXW-1:0] head [4];
  logic [IDXW-1:0] tail [4];
  logic [31:0]     mem  [4*MAXE];
  logic            en, pie, oie, ovf;
  logic [5:0]      szc;
  logic [11:0]     base_hi;
  logic [IDXW-1:0] mask;
  logic [3:0]      empty, full;
  logic [31:0]     rd_val;

  assign mask = IDXW'(32'(szc) * UNIT_ENTRIES - 1);

  always_comb begin
    for (int q = 0; q < 4; q++) begin
      empty[q] = ((head[q] ^ tail[q]) & mask) == '0;
      full[q]  = ((head[q] + 1'b1) & mask) == (tail[q] & mask);
    end
  end

  wire wr_eff   = bus_wr & ~bus_rd;
  wire is_in    = bus_addr == A_INPORT;
  wire is_out   = bus_addr == A_OUTPORT;
  wire is_port  = is_in | is_out;
  wire is_store = bus_addr[ADDR_W-1];
  wire is_ptr   = (bus_addr[ADDR_W-1:8] == 1) && (bus_addr[7:4] >= 4'd2) &&
                  (bus_addr[7:4] <= 4'd5) && (bus_addr[2:0] == 3'd0);
  wire [1:0] ptr_q  = 2'(bus_addr[7:4] - 4'd2);
  wire       ptr_tl = bus_addr[3];
  wire [1:0] pop_q  = is_in ? 2'd0 : 2'd3;
  wire [1:0] push_q = is_in ? 2'd1 : 2'd2;
  wire [MEMW-1:0] st_idx = bus_addr[MEMW+1:2];
  wire pop_ok  = bus_rd & is_port & en & ~empty[pop_q];
  wire push_ok = wr_eff & is_port & en & ~full[push_q];
  wire push_ov = wr_eff & is_port & en &  full[push_q];
  wire [5:0] szc_w  = bus_wdata[13:8];
  wire       szc_ok = $onehot(szc_w) && !szc_w[0];

  always_comb begin
    rd_val = '0;
    if (is_store)     rd_val = mem[st_idx];
    else if (is_port) rd_val = pop_ok ? mem[{pop_q, tail[pop_q] & mask}] : '1;
    else if (is_ptr)  rd_val = 32'(ptr_tl ? tail[ptr_q] : head[ptr_q]);
    else if (bus_addr == A_CTRL)
      rd_val = {15'd0, ovf, 2'd0, szc, 5'd0, oie, pie, en};
    else if (bus_addr == A_BASE)
      rd_val = {base_hi, 20'd0};
  end

  always_ff @(posedge clk) begin
    if (wr_eff && is_store)
      mem[st_idx] <= bus_wdata;
    else if (push_ok)
      mem[{push_q, head[push_q] & mask}] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < 4; q++) begin
        head[q] <= '0;
        tail[q] <= '0;
      end
      en        <= 1'b0;
      pie       <= 1'b0;
      oie       <= 1'b0;
      ovf       <= 1'b0;
      szc       <= 6'h02;
      base_hi   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd) begin
        bus_rdata <= rd_val;
        if (pop_ok) tail[pop_q] <= (tail[pop_q] + 1'b1) & mask;
      end
      if (push_ok) head[push_q] <= (head[push_q] + 1'b1) & mask;
      if (push_ov) ovf <= 1'b1;
      if (wr_eff && is_ptr) begin
        if (ptr_tl) tail[ptr_q] <= bus_wdata[IDXW-1:0] & mask;
        else        head[ptr_q] <= bus_wdata[IDXW-1:0] & mask;
      end
      if (wr_eff && bus_addr == A_CTRL) begin
        en  <= bus_wdata[0];
        pie <= bus_wdata[1];
        oie <= bus_wdata[2];
        if (szc_ok)       szc <= szc_w;
        if (bus_wdata[16]) ovf <= 1'b0;
      end
      if (wr_eff && bus_addr == A_BASE) base_hi <= bus_wdata[31:20];
    end
  end

  assign irq_local  = en & ((pie & ~empty[1]) | (oie & ovf));
  assign irq_remote = en & pie & ~empty[3];

  AST_EMPTY_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_in && empty[0]) |=> bus_rdata == 32'hFFFF_FFFF); // R7
  AST_EMPTY_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_out && empty[3]) |=> $stable(tail[3])); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eff && is_in && en && full[1]) |=> (ovf && $stable(head[1]))); // R8
  AST_POP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_in && en && !empty[0] && (tail[0] & mask) == mask) |=> tail[0] == '0); // R9
  AST_REMOTE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_remote |-> (en && head[3] != tail[3])); // R10
endmodule

// File: tb/test_msg_queue_mgr.sv
module test_msg_queue_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;
  // {req[3:0], rd, wr, chk, addr[15:0], wdata[31:0], expected[31:0]}
  localparam logic [86:0] VEC [NV] = '{
    {4'd2,  3'b010, 16'h0164, 32'h0000_0203, 32'h0},
    {4'd2,  3'b101, 16'h0164, 32'h0,         32'h0000_0203}, // R2
    {4'd7,  3'b101, 16'h0040, 32'h0,         32'hFFFF_FFFF}, // R7
    {4'd12, 3'b010, 16'h1000, 32'hA000_0100, 32'h0},
    {4'd9,  3'b010, 16'h0120, 32'h1,         32'h0},
    {4'd9,  3'b101, 16'h0120, 32'h0,         32'h1},         // R9
    {4'd3,  3'b101, 16'h0040, 32'h0,         32'hA000_0100}, // R3
    {4'd3,  3'b101, 16'h0128, 32'h0,         32'h1},         // R3
    {4'd7,  3'b101, 16'h0040, 32'h0,         32'hFFFF_FFFF}, // R7
    {4'd7,  3'b101, 16'h0128, 32'h0,         32'h1},         // R7
    {4'd4,  3'b010, 16'h0040, 32'hB000_0200, 32'h0},
    {4'd4,  3'b101, 16'h0130, 32'h0,         32'h1},         // R4
    {4'd12, 3'b101, 16'h1200, 32'h0,         32'hB000_0200}, // R12
    {4'd6,  3'b010, 16'h0044, 32'hC000_0300, 32'h0},
    {4'd6,  3'b101, 16'h0140, 32'h0,         32'h1},         // R6
    {4'd6,  3'b101, 16'h1400, 32'h0,         32'hC000_0300}, // R6
    {4'd7,  3'b101, 16'h0044, 32'h0,         32'hFFFF_FFFF}, // R7
    {4'd12, 3'b010, 16'h1600, 32'hD000_0400, 32'h0},
    {4'd5,  3'b010, 16'h0150, 32'h1,         32'h0},
    {4'd5,  3'b101, 16'h0044, 32'h0,         32'hD000_0400}, // R5
    {4'd5,  3'b101, 16'h0158, 32'h0,         32'h1},         // R5
    {4'd11, 3'b010, 16'h0170, 32'h1234_5678, 32'h0},
    {4'd11, 3'b101, 16'h0170, 32'h0,         32'h1230_0000}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_local, irq_remote;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_queue_mgr i_msg_queue_mgr (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_local(irq_local), .irq_remote(irq_remote));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic rd, input logic wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a[12:0]; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    op(1'b0, 1'b1, a, d);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    op(1'b1, 1'b0, a, '0);
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    check("R1 irq_local", 32'(irq_local), 32'h0);
    check("R1 irq_remote", 32'(irq_remote), 32'h0);
    rd_chk("R1 ctrl", 16'h0164, 32'h0000_0200);
    rd_chk("R1 pointer", 16'h0150, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][82], VEC[i][81], VEC[i][79:64], VEC[i][63:32]);
      if (VEC[i][80])
        check($sformatf("R%0d row %0d", VEC[i][86:83], i), bus_rdata, VEC[i][31:0]);
    end

    check("R10 post irq", 32'(irq_local), 32'h1);
    check("R10 remote idle", 32'(irq_remote), 32'h0);
    wr(16'h0138, 32'h1);
    check("R10 post irq drop", 32'(irq_local), 32'h0);

    for (int k = 0; k < 7; k++) wr(16'h0040, 32'hF000_0000 + 32'(k));
    rd_chk("R9 head wrap", 16'h0130, 32'h0);
    check("R10 post irq again", 32'(irq_local), 32'h1);
    wr(16'h0040, 32'hEEEE_EEEE);
    rd_chk("R8 head kept", 16'h0130, 32'h0);
    rd_chk("R8 ovf flag", 16'h0164, 32'h0001_0203);
    rd_chk("R8 oldest kept", 16'h1000 + 16'h0200 + 16'h4, 32'hF000_0000);
    wr(16'h0164, 32'h0001_0203);
    rd_chk("R8 ovf clear", 16'h0164, 32'h0000_0203);

    wr(16'h1004, 32'hE000_0500);
    wr(16'h0120, 32'h2);
    wr(16'h0164, 32'h0000_0200);
    check("R10 disabled", 32'(irq_local), 32'h0);
    rd_chk("R7 disabled read", 16'h0040, 32'hFFFF_FFFF);
    rd_chk("R7 disabled tail", 16'h0128, 32'h1);
    wr(16'h0040, 32'h1234_0000);
    rd_chk("R7 disabled post", 16'h0130, 32'h0);

    wr(16'h0164, 32'h0000_0401);
    rd_chk("R2 size 8k", 16'h0164, 32'h0000_0401);
    wr(16'h0140, 32'h25);
    rd_chk("R9 pointer mask", 16'h0140, 32'h5);
    wr(16'h0164, 32'h0000_0301);
    rd_chk("R2 bad size", 16'h0164, 32'h0000_0401);

    wr(16'h0164, 32'h0000_0405);
    wr(16'h0130, 32'h0);
    wr(16'h0138, 32'h1);
    check("R10 no ovf yet", 32'(irq_local), 32'h0);
    wr(16'h0040, 32'h5555_0000);
    check("R10 ovf irq", 32'(irq_local), 32'h1);
    rd_chk("R8 ovf size 8k", 16'h0164, 32'h0001_0405);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule